// File: doc/BRIEF.md
# Flash Program and Status-Poll Controller

This block sits on the host side of an asynchronous 8-bit parallel flash bus. It takes one request at a time, carrying an operation (byte program, sector erase or whole-chip erase), a target address and a data byte. It then plays out the unlock-and-command write cycles that the flash expects. Every bus edge is timed by counting cycles of the system clock, and the number of cycles in each strobe phase is set by a parameter.

Once the command is written, the controller reads the status byte at the target address again and again until the embedded operation inside the flash has ended. Status can be checked in one of two ways: by comparing the completion bit against its expected value, or by watching whether the toggle bit has stopped changing. When the time-limit bit rises, the controller reads one more time before it decides. This extra read stops a device that finishes at the same moment its time-limit bit goes high from being reported as failed. After a failure the controller writes the reset command so that the flash returns to read mode. Only then does it report the result.

Top module: `flash_prog_ctrl`

## Requirements
- R1: A program request (`req_op_i` = 2'b00) produces four writes in this order: AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then `req_data_i` at `req_addr_i`.
- R2: A sector-erase request (`req_op_i` = 2'b01) produces six writes: AAh/5555h, 55h/2AAAh, 80h/5555h, AAh/5555h, 55h/2AAAh, then 30h at `req_addr_i`.
- R3: A chip-erase request (`req_op_i` = 2'b10 or 2'b11) produces the same first five writes as R2, then 10h at 5555h.
- R4: Each write holds `fb_we_no` low for exactly WE_LOW_CYC cycles. Address and data are driven (`fb_dq_oe_o` = 1) and held stable from at least one cycle before the falling edge until the rising edge. `fb_we_no` stays high for at least WE_HIGH_CYC cycles between pulses. `fb_we_no` and `fb_oe_no` are never low together.
- R5: Each status read holds `fb_oe_no` low for exactly OE_LOW_CYC cycles at address `req_addr_i`, with the data driver off. The status byte is captured in the last low cycle.
- R6: Data-poll mode (`req_toggle_i` = 0) expects status bit 7 to equal `req_data_i[7]` for a program and 1 for either erase. If bit 7 matches, the result is pass. If bit 7 does not match and status bit 5 is 0, the controller reads again.
- R7: In data-poll mode, if bit 7 does not match and bit 5 is 1, the controller makes exactly one more read. The result is pass if bit 7 matches on that read and fail if it does not.
- R8: Toggle mode (`req_toggle_i` = 1) compares status bit 6 across consecutive reads. If bit 6 is unchanged, the result is pass. If it changed and bit 5 is 0, the controller keeps reading. If it changed and bit 5 is 1, the controller makes one more read: the result is pass if bit 6 is then unchanged and fail otherwise.
- R9: After a fail, and before it reports, the controller writes F0h at 5555h. No reset write is issued after a pass.
- R10: `busy_o` rises in the cycle after a request is accepted. `done_o` is a single-cycle pulse while `busy_o` is high, with the result on `pass_o` (1 = pass). `busy_o` is low in the following cycle.
- R11: A request seen while `busy_o` is high is ignored: it produces no bus cycle and no result.
- R12: Out of reset the bus is idle (`fb_ce_no`, `fb_we_no` and `fb_oe_no` all high), and `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_op_i | input | 2 | 00 program, 01 sector erase, 1x chip erase |
| req_toggle_i | input | 1 | 0 data-poll status check, 1 toggle check |
| req_addr_i | input | ADDR_W | Target byte, or any address in the sector; also the poll address |
| req_data_i | input | 8 | Byte to program |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Outcome, valid with done_o |
| fb_addr_o | output | ADDR_W | Flash address bus |
| fb_dq_o | output | 8 | Flash write data |
| fb_dq_oe_o | output | 1 | Enable for the write-data driver |
| fb_dq_i | input | 8 | Flash read data |
| fb_ce_no | output | 1 | Chip enable, active low |
| fb_we_no | output | 1 | Write strobe, active low |
| fb_oe_no | output | 1 | Output enable, active low |

## Verification
Each write completes on the rising edge of `fb_we_no`, which comes one setup cycle plus WE_LOW_CYC cycles after the strobe sequence starts. The monitor checks the address and data in the first falling-edge sample where the strobe is seen high again, because both are still held during recovery. A status read takes effect at the edge that ends its OE_LOW_CYC-cycle low phase. The result follows when the deciding read's recovery ends, or one write later after a fail, and it appears as a `done_o` pulse one cycle after that. The monitor samples on every falling clock edge, so it cannot miss the one-cycle pulse. It then expects `busy_o` to be low on the next falling edge.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

  localparam logic [15:0] UNLK_ADDR_A = 16'h5555;
  localparam logic [15:0] UNLK_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  UNLK_DATA_A = 8'hAA;
  localparam logic [7:0]  UNLK_DATA_B = 8'h55;
  localparam logic [7:0]  CMD_PROG    = 8'hA0;
  localparam logic [7:0]  CMD_ERASE   = 8'h80;
  localparam logic [7:0]  CMD_CHIP    = 8'h10;
  localparam logic [7:0]  CMD_SECT    = 8'h30;
  localparam logic [7:0]  CMD_RESET   = 8'hF0;

  localparam int ST_POLL_BIT   = 7;
  localparam int ST_TOGGLE_BIT = 6;
  localparam int ST_LIMIT_BIT  = 5;

  typedef enum logic [1:0] {K_PROG, K_SECT, K_CHIP} op_kind_e;

  typedef enum logic [2:0] {V_WAIT, V_PRIME, V_RECHK, V_PASS, V_FAIL} verdict_e;

  typedef struct packed {
    logic        at_tgt;
    logic [15:0] uaddr;
    logic [7:0]  data;
  } cmd_step_t;

  function automatic op_kind_e decode_op(logic [1:0] op);
    if (op == 2'b00)      return K_PROG;
    else if (op == 2'b01) return K_SECT;
    else                  return K_CHIP;
  endfunction

  function automatic logic [2:0] last_step(op_kind_e k);
    return (k == K_PROG) ? 3'd3 : 3'd5;
  endfunction

  function automatic cmd_step_t cmd_step(op_kind_e k, logic [2:0] idx, logic [7:0] pdata);
    cmd_step_t s;
    s = '{at_tgt: 1'b0, uaddr: UNLK_ADDR_A, data: UNLK_DATA_A};
    case (idx)
      3'd0: s = '{1'b0, UNLK_ADDR_A, UNLK_DATA_A};
      3'd1: s = '{1'b0, UNLK_ADDR_B, UNLK_DATA_B};
      3'd2: s = '{1'b0, UNLK_ADDR_A, (k == K_PROG) ? CMD_PROG : CMD_ERASE};
      3'd3: s = (k == K_PROG) ? '{1'b1, 16'h0000, pdata} : '{1'b0, UNLK_ADDR_A, UNLK_DATA_A};
      3'd4: s = '{1'b0, UNLK_ADDR_B, UNLK_DATA_B};
      default: s = (k == K_SECT) ? '{1'b1, 16'h0000, CMD_SECT} : '{1'b0, UNLK_ADDR_A, CMD_CHIP};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/flash_bus_phy.sv
module flash_bus_phy #(
  parameter int ADDR_W      = 19,
  parameter int WE_LOW_CYC  = 13,
  parameter int WE_HIGH_CYC = 10,
  parameter int OE_LOW_CYC  = 20,
  parameter int OE_HIGH_CYC = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              idle_o,
  output logic              done_o,
  output logic [7:0]        rdata_o,
  output logic [ADDR_W-1:0] fb_addr_o,
  output logic [7:0]        fb_dq_o,
  output logic              fb_dq_oe_o,
  input  logic [7:0]        fb_dq_i,
  output logic              fb_ce_no,
  output logic              fb_we_no,
  output logic              fb_oe_no
);

  localparam int MAX_AB = (WE_LOW_CYC > WE_HIGH_CYC) ? WE_LOW_CYC : WE_HIGH_CYC;
  localparam int MAX_CD = (OE_LOW_CYC > OE_HIGH_CYC) ? OE_LOW_CYC : OE_HIGH_CYC;
  localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W  = $clog2(MAXC + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACT, PH_REC} ph_e;

  ph_e              st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, act_last, rec_last;
  logic             rd_q, rd_d, launch;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]       wdata_q, rdata_q;
  logic             ce_q, we_q, oe_q, drv_q;

  assign launch   = (st_q == PH_IDLE) && start_i;
  assign rd_d     = launch ? rd_i : rd_q;
  assign act_last = rd_q ? CNT_W'(OE_LOW_CYC - 1)  : CNT_W'(WE_LOW_CYC - 1);
  assign rec_last = rd_q ? CNT_W'(OE_HIGH_CYC - 1) : CNT_W'(WE_HIGH_CYC - 1);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_o = 1'b0;
    case (st_q)
      PH_IDLE:  if (start_i) begin st_d = PH_SETUP; cnt_d = '0; end
      PH_SETUP: begin st_d = PH_ACT; cnt_d = '0; end
      PH_ACT: begin
        if (cnt_q == act_last) begin st_d = PH_REC; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      default: begin
        if (cnt_q == rec_last) begin st_d = PH_IDLE; cnt_d = '0; done_o = 1'b1; end
        else cnt_d = cnt_q + 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= PH_IDLE;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      ce_q    <= 1'b1;
      we_q    <= 1'b1;
      oe_q    <= 1'b1;
      drv_q   <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      rd_q  <= rd_d;
      if (launch) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (st_q == PH_ACT && rd_q && cnt_q == act_last) rdata_q <= fb_dq_i;
      // strobes registered from next state: glitch-free pins
      ce_q  <= (st_d == PH_IDLE);
      we_q  <= !(st_d == PH_ACT && !rd_d);
      oe_q  <= !(st_d == PH_ACT && rd_d);
      drv_q <= (st_d != PH_IDLE) && !rd_d;
    end
  end

  assign idle_o     = (st_q == PH_IDLE);
  assign rdata_o    = rdata_q;
  assign fb_addr_o  = addr_q;
  assign fb_dq_o    = wdata_q;
  assign fb_dq_oe_o = drv_q;
  assign fb_ce_no   = ce_q;
  assign fb_we_no   = we_q;
  assign fb_oe_no   = oe_q;

endmodule

// File: rtl/flash_poll_eval.sv
module flash_poll_eval
  import flash_prog_pkg::*;
(
  input  logic     toggle_i,
  input  logic     first_i,
  input  logic     rechk_i,
  input  logic     exp7_i,
  input  logic     prev6_i,
  input  logic [7:0] rdata_i,
  output verdict_e verdict_o
);

  logic poll_ok, tog_still, limit;

  assign poll_ok   = (rdata_i[ST_POLL_BIT] == exp7_i);
  assign tog_still = (rdata_i[ST_TOGGLE_BIT] == prev6_i);
  assign limit     = rdata_i[ST_LIMIT_BIT];

  always_comb begin
    verdict_o = V_WAIT;
    if (!toggle_i) begin
      if (poll_ok)      verdict_o = V_PASS;
      else if (rechk_i) verdict_o = V_FAIL;
      else if (limit)   verdict_o = V_RECHK;
    end else begin
      if (first_i)        verdict_o = V_PRIME;
      else if (tog_still) verdict_o = V_PASS;
      else if (rechk_i)   verdict_o = V_FAIL;
      else if (limit)     verdict_o = V_RECHK;
    end
  end

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic              req_toggle_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [7:0]        req_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              phy_start_o,
  output logic              phy_rd_o,
  output logic [ADDR_W-1:0] phy_addr_o,
  output logic [7:0]        phy_wdata_o,
  input  logic              phy_idle_i,
  input  logic              phy_done_i,
  input  logic [7:0]        phy_rdata_i,
  input  verdict_e          verdict_i,
  output logic              ev_toggle_o,
  output logic              ev_first_o,
  output logic              ev_rechk_o,
  output logic              ev_exp7_o,
  output logic              ev_prev6_o
);

  typedef enum logic [2:0] {SQ_IDLE, SQ_WR, SQ_RD, SQ_RST, SQ_FIN} sq_e;

  sq_e               st_q;
  op_kind_e          kind_q;
  logic              tog_q, pend_q, first_q, rechk_q, prev6_q, pass_q;
  logic [2:0]        step_q;
  logic [ADDR_W-1:0] tgt_addr_q;
  logic [7:0]        tgt_data_q;
  cmd_step_t         cs;
  logic              on_bus;

  assign cs          = cmd_step(kind_q, step_q, tgt_data_q);
  assign on_bus      = (st_q == SQ_WR) || (st_q == SQ_RD) || (st_q == SQ_RST);
  assign phy_start_o = on_bus && !pend_q && phy_idle_i;
  assign phy_rd_o    = (st_q == SQ_RD);

  always_comb begin
    phy_addr_o  = tgt_addr_q;
    phy_wdata_o = '0;
    case (st_q)
      SQ_WR: begin
        phy_addr_o  = cs.at_tgt ? tgt_addr_q : ADDR_W'(cs.uaddr);
        phy_wdata_o = cs.data;
      end
      SQ_RST: begin
        phy_addr_o  = ADDR_W'(UNLK_ADDR_A);
        phy_wdata_o = CMD_RESET;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= SQ_IDLE;
      kind_q     <= K_PROG;
      tog_q      <= 1'b0;
      pend_q     <= 1'b0;
      first_q    <= 1'b1;
      rechk_q    <= 1'b0;
      prev6_q    <= 1'b0;
      pass_q     <= 1'b0;
      step_q     <= '0;
      tgt_addr_q <= '0;
      tgt_data_q <= '0;
    end else begin
      if (phy_start_o)     pend_q <= 1'b1;
      else if (phy_done_i) pend_q <= 1'b0;
      case (st_q)
        SQ_IDLE: if (req_valid_i) begin
          kind_q     <= decode_op(req_op_i);
          tog_q      <= req_toggle_i;
          tgt_addr_q <= req_addr_i;
          tgt_data_q <= req_data_i;
          step_q     <= '0;
          first_q    <= 1'b1;
          rechk_q    <= 1'b0;
          pass_q     <= 1'b0;
          st_q       <= SQ_WR;
        end
        SQ_WR: if (phy_done_i) begin
          if (step_q == last_step(kind_q)) st_q <= SQ_RD;
          else step_q <= step_q + 3'd1;
        end
        SQ_RD: if (phy_done_i) begin
          prev6_q <= phy_rdata_i[ST_TOGGLE_BIT];
          first_q <= 1'b0;
          case (verdict_i)
            V_RECHK: rechk_q <= 1'b1;
            V_PASS:  begin pass_q <= 1'b1; st_q <= SQ_FIN; end
            V_FAIL:  st_q <= SQ_RST;
            default: ;
          endcase
        end
        SQ_RST: if (phy_done_i) st_q <= SQ_FIN;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != SQ_IDLE);
  assign done_o      = (st_q == SQ_FIN);
  assign pass_o      = pass_q;
  assign ev_toggle_o = tog_q;
  assign ev_first_o  = first_q;
  assign ev_rechk_o  = rechk_q;
  assign ev_exp7_o   = (kind_q == K_PROG) ? tgt_data_q[ST_POLL_BIT] : 1'b1;
  assign ev_prev6_o  = prev6_q;

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int WE_LOW_CYC  = 13,
  parameter int WE_HIGH_CYC = 10,
  parameter int OE_LOW_CYC  = 20,
  parameter int OE_HIGH_CYC = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic              req_toggle_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [7:0]        req_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic [ADDR_W-1:0] fb_addr_o,
  output logic [7:0]        fb_dq_o,
  output logic              fb_dq_oe_o,
  input  logic [7:0]        fb_dq_i,
  output logic              fb_ce_no,
  output logic              fb_we_no,
  output logic              fb_oe_no
);

  logic              phy_start, phy_rd, phy_idle, phy_done;
  logic [ADDR_W-1:0] phy_addr;
  logic [7:0]        phy_wdata, phy_rdata;
  logic              ev_toggle, ev_first, ev_rechk, ev_exp7, ev_prev6;
  verdict_e          verdict;

  flash_prog_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i, .rst_ni, .req_valid_i, .req_op_i, .req_toggle_i, .req_addr_i, .req_data_i,
    .busy_o, .done_o, .pass_o,
    .phy_start_o (phy_start),
    .phy_rd_o    (phy_rd),
    .phy_addr_o  (phy_addr),
    .phy_wdata_o (phy_wdata),
    .phy_idle_i  (phy_idle),
    .phy_done_i  (phy_done),
    .phy_rdata_i (phy_rdata),
    .verdict_i   (verdict),
    .ev_toggle_o (ev_toggle),
    .ev_first_o  (ev_first),
    .ev_rechk_o  (ev_rechk),
    .ev_exp7_o   (ev_exp7),
    .ev_prev6_o  (ev_prev6)
  );

  flash_poll_eval u_eval (
    .toggle_i  (ev_toggle),
    .first_i   (ev_first),
    .rechk_i   (ev_rechk),
    .exp7_i    (ev_exp7),
    .prev6_i   (ev_prev6),
    .rdata_i   (phy_rdata),
    .verdict_o (verdict)
  );

  flash_bus_phy #(
    .ADDR_W(ADDR_W), .WE_LOW_CYC(WE_LOW_CYC), .WE_HIGH_CYC(WE_HIGH_CYC),
    .OE_LOW_CYC(OE_LOW_CYC), .OE_HIGH_CYC(OE_HIGH_CYC)
  ) u_phy (
    .clk_i, .rst_ni,
    .start_i  (phy_start),
    .rd_i     (phy_rd),
    .addr_i   (phy_addr),
    .wdata_i  (phy_wdata),
    .idle_o   (phy_idle),
    .done_o   (phy_done),
    .rdata_o  (phy_rdata),
    .fb_addr_o, .fb_dq_o, .fb_dq_oe_o, .fb_dq_i, .fb_ce_no, .fb_we_no, .fb_oe_no
  );

endmodule

// File: rtl/flash_prog_ctrl_chk.sv
module flash_prog_ctrl_chk #(
  parameter int ADDR_W      = 19,
  parameter int WE_LOW_CYC  = 13,
  parameter int WE_HIGH_CYC = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] fb_addr_o,
  input logic [7:0]        fb_dq_o,
  input logic              fb_dq_oe_o,
  input logic              fb_ce_no,
  input logic              fb_we_no,
  input logic              fb_oe_no
);

  logic [15:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt <= '0;
      hi_cnt <= 16'hFFFF;
    end else begin
      lo_cnt <= fb_we_no ? 16'd0 : lo_cnt + 16'd1;
      if (!fb_we_no)             hi_cnt <= '0;
      else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!fb_we_no && !fb_oe_no)); // R4

  AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fb_we_no |-> fb_dq_oe_o && !fb_ce_no && $stable(fb_dq_o) && $stable(fb_addr_o)); // R4

  AST_WE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fb_we_no) |-> lo_cnt == 16'(WE_LOW_CYC)); // R4

  AST_WE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fb_we_no) |-> hi_cnt >= 16'(WE_HIGH_CYC)); // R4

  AST_RD_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fb_oe_no |-> !fb_dq_oe_o && !fb_ce_no); // R5

  AST_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !busy_o |=> busy_o); // R10

  AST_DONE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o); // R10

  AST_DONE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o && !done_o); // R10

  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> fb_ce_no && fb_we_no && fb_oe_no); // R12

endmodule

bind flash_prog_ctrl flash_prog_ctrl_chk #(
  .ADDR_W(ADDR_W), .WE_LOW_CYC(WE_LOW_CYC), .WE_HIGH_CYC(WE_HIGH_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .busy_o(busy_o),
  .done_o(done_o), .fb_addr_o(fb_addr_o), .fb_dq_o(fb_dq_o), .fb_dq_oe_o(fb_dq_oe_o),
  .fb_ce_no(fb_ce_no), .fb_we_no(fb_we_no), .fb_oe_no(fb_oe_no)
);

// File: tb/flash_prog_ctrl_tb.sv
module flash_prog_ctrl_tb;

  localparam int AW = 19;
  localparam int WL = 13;
  localparam int WH = 10;
  localparam int OL = 20;
  localparam int OH = 6;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [1:0]    req_op_i = '0;
  logic          req_toggle_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [7:0]    req_data_i = '0;
  logic          busy_o, done_o, pass_o;
  logic [AW-1:0] fb_addr_o;
  logic [7:0]    fb_dq_o, fb_dq_i;
  logic          fb_dq_oe_o, fb_ce_no, fb_we_no, fb_oe_no;

  always #2 clk_i = ~clk_i;

  flash_prog_ctrl #(.ADDR_W(AW), .WE_LOW_CYC(WL), .WE_HIGH_CYC(WH),
                    .OE_LOW_CYC(OL), .OE_HIGH_CYC(OH)) u_dut (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [AW+7:0] wr_q[$];
  string         wr_tag_q[$];
  bit            res_q[$];
  string         res_tag_q[$];

  int            mdl_busy = 0;
  int            mdl_to = 0;
  int            mdl_cnt = 0;
  logic [7:0]    mdl_final = '0;
  logic [AW-1:0] poll_addr = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // flash status model: busy for mdl_busy reads, limit bit from read mdl_to on
  function automatic logic [7:0] mdl_status(int k, int nb, int nt, logic [7:0] fin);
    if (k < nb) return {~fin[7], (k % 2 == 1), (k >= nt), 5'b0};
    return fin;
  endfunction

  always_comb fb_dq_i = mdl_status(mdl_cnt, mdl_busy, mdl_to, mdl_final);

  // monitor
  bit  we_prev = 1, oe_prev = 1, busy_prev = 0, chk_fall = 0, rd_drv = 0;
  int  lo_we = 0, lo_oe = 0;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      we_prev = 1; oe_prev = 1; busy_prev = 0; chk_fall = 0;
      lo_we = 0; lo_oe = 0; rd_drv = 0;
    end else begin
      if (busy_o && !busy_prev) mdl_cnt = 0;
      if (chk_fall) begin
        check(!busy_o, "R10", "busy after done", busy_o, 0);
        chk_fall = 0;
      end
      if (!fb_we_no) lo_we++;
      if (!fb_oe_no) begin lo_oe++; rd_drv |= fb_dq_oe_o; end
      if (fb_we_no && !we_prev) begin
        check(lo_we == WL, "R4", "WE low cycles", lo_we, WL);
        if (wr_q.size() == 0) begin
          check(0, "R11", "unexpected write", {fb_addr_o, fb_dq_o}, 0);
        end else begin
          logic [AW+7:0] e;
          string t;
          e = wr_q.pop_front();
          t = wr_tag_q.pop_front();
          check({fb_addr_o, fb_dq_o} == e, t, "write addr/data", {fb_addr_o, fb_dq_o}, e);
        end
        lo_we = 0;
      end
      if (fb_oe_no && !oe_prev) begin
        check(lo_oe == OL, "R5", "OE low cycles", lo_oe, OL);
        check(fb_addr_o == poll_addr, "R5", "poll address", fb_addr_o, poll_addr);
        check(!rd_drv, "R5", "driver off during read", rd_drv, 0);
        mdl_cnt++;
        lo_oe = 0; rd_drv = 0;
      end
      if (done_o) begin
        if (res_q.size() == 0) begin
          check(0, "R11", "unexpected result", pass_o, 0);
        end else begin
          bit    e;
          string t;
          e = res_q.pop_front();
          t = res_tag_q.pop_front();
          check(pass_o == e, t, "pass outcome", pass_o, e);
        end
        chk_fall = 1;
      end
      we_prev = fb_we_no; oe_prev = fb_oe_no; busy_prev = busy_o;
    end
  end

  task automatic push_wr(input logic [AW-1:0] a, input logic [7:0] d, input string t);
    wr_q.push_back({a, d});
    wr_tag_q.push_back(t);
  endtask

  task automatic run_op(input logic [1:0] op, input bit tog, input logic [AW-1:0] a,
                        input logic [7:0] d, input int nb, input int nt,
                        input bit exp_pass, input string tag, input bit poke);
    string ct;
    ct = (op == 2'b00) ? "R1" : (op == 2'b01) ? "R2" : "R3";
    push_wr(19'h05555, 8'hAA, ct);
    push_wr(19'h02AAA, 8'h55, ct);
    if (op == 2'b00) begin
      push_wr(19'h05555, 8'hA0, ct);
      push_wr(a, d, ct);
    end else begin
      push_wr(19'h05555, 8'h80, ct);
      push_wr(19'h05555, 8'hAA, ct);
      push_wr(19'h02AAA, 8'h55, ct);
      if (op == 2'b01) push_wr(a, 8'h30, ct);
      else             push_wr(19'h05555, 8'h10, ct);
    end
    if (!exp_pass) push_wr(19'h05555, 8'hF0, "R9");
    res_q.push_back(exp_pass);
    res_tag_q.push_back(tag);
    mdl_busy  = nb;
    mdl_to    = nt;
    mdl_final = (op == 2'b00) ? d : 8'hFF;
    poll_addr = a;
    @(negedge clk_i);
    req_op_i = op; req_toggle_i = tog; req_addr_i = a; req_data_i = d; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(busy_o, "R10", "busy after accept", busy_o, 1);
    if (poke) begin
      repeat (8) @(negedge clk_i);
      req_op_i = 2'b10; req_addr_i = 19'h7FFFF; req_valid_i = 1'b1;
      repeat (3) @(negedge clk_i);
      req_valid_i = 1'b0;
    end
    while (res_q.size() != 0) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    check(wr_q.size() == 0, tag, "all writes seen", wr_q.size(), 0);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R12 reset state
    check(!busy_o && !done_o, "R12", "busy/done idle", {busy_o, done_o}, 0);
    check(fb_ce_no && fb_we_no && fb_oe_no, "R12", "bus idle",
          {fb_ce_no, fb_we_no, fb_oe_no}, 3'b111);
    // R1 R6 program, expected bit7 0
    run_op(2'b00, 0, 19'h12345, 8'h5A, 3, 99, 1, "R6", 0);
    // R6 program, expected bit7 1
    run_op(2'b00, 0, 19'h00010, 8'hC3, 2, 99, 1, "R6", 0);
    // R2 R6 sector erase, data poll
    run_op(2'b01, 0, 19'h30010, 8'h00, 4, 99, 1, "R6", 0);
    // R3 R8 chip erase with toggle, op 11
    run_op(2'b11, 1, 19'h00000, 8'h00, 5, 99, 1, "R8", 0);
    // R7 limit bit rises on last busy read: recheck gives pass
    run_op(2'b00, 0, 19'h4ABCD, 8'h81, 5, 4, 1, "R7", 0);
    // R7 R9 stuck erase: fail then reset write
    run_op(2'b01, 0, 19'h52000, 8'h00, 1000, 2, 0, "R7", 0);
    // R8 toggle race resolves to pass
    run_op(2'b01, 1, 19'h61111, 8'h00, 4, 3, 1, "R8", 0);
    // R8 R9 toggle never stops: fail
    run_op(2'b00, 1, 19'h00777, 8'h00, 1000, 3, 0, "R8", 0);
    // R11 request while busy ignored
    run_op(2'b00, 0, 19'h23456, 8'h3C, 6, 99, 1, "R11", 1);
    check(!busy_o, "R11", "no second accept", busy_o, 0);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

endmodule